// File: doc/BRIEF.md
# BCD Time-of-Day Clock Register Block

This block keeps calendar time as packed BCD values: seconds, minutes, hours, day of week, date of month, month and a two-digit year. Each packed value holds the tens digit in its upper nibble and the units digit in its lower nibble. The values are exposed as eight byte-wide registers on a simple synchronous bus. The bus has an address, a write strobe, write data and combinational read data.

A periodic tick input drives a sub-second divider. One second passes every `SUBSEC_DIV` tick pulses, and each second advances the calendar through the full carry chain. The chain handles month lengths and leap years.

A control register decides how software reaches the time values.
- **Write-hold bit.** Setting it sends time-field writes to a holding copy. Clearing it moves that copy into the live counters in one cycle.
- **Read-freeze bit.** Setting it pins the readable copy, so a multi-byte read sees one consistent time.
- **Spare control bits.** The oscillator-stop flag, the kick flag and the frequency-test flag live in otherwise unused high bits of the seconds, hours and day-of-week registers.

Top module: `tod_bcd_clock`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, date 0x01, month 0x01, year 0x00 and control 0x00.
- R2: The block occupies addresses 0x7F8..0x7FF, with address bits [2:0] selecting the register: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. Reads of any other address return 0x00, and writes to any other address change nothing.
- R3: Seconds advance by one in BCD on every `SUBSEC_DIV`-th tick pulse (default 4), so the units digit rolls from 9 to 0 with a tens carry (0x09 to 0x10). Fewer pulses leave the value unchanged.
- R4: The carry chain behaves as follows.
  - Seconds 0x59 wrap to 0x00 and carry into minutes.
  - Minutes 0x59 wrap to 0x00 and carry into hours.
  - Hours 0x23 wrap to 0x00 and advance both the day of week and the date.
  - Day of week wraps from 0x07 to 0x01.
- R5: The date wraps to 0x01 and advances the month after the month's last day.
  - The last day is 0x30 for months 0x04, 0x06, 0x09 and 0x11.
  - The last day is 0x31 for all other months except month 0x02.
  - Month 0x02 ends at 0x29 when the year is a multiple of four (counting 0x00), and at 0x28 otherwise.
- R6: Month 0x12 wraps to 0x01 and advances the year. Year 0x99 wraps to 0x00.
- R7: Control bit 7 is the write-hold bit. While it is set, writes to time fields go to a holding copy, masked to the field width, and time reads return that holding copy. While it is clear, writes to time fields are ignored.
- R8: A control write that clears bit 7 while it is set loads the holding copy into the live count at that clock edge. The same edge clears the sub-second divider, so the next second elapses exactly `SUBSEC_DIV` pulses later.
- R9: Control bit 6 is the read-freeze bit. While it is set, time reads return a copy frozen at the moment it was set. After it clears, reads return the live count, which kept running.
- R10: Control bits 5 (sign) and 4..0 (calibration) are stored and read back, and have no effect on counting.
- R11: Bit 7 of the seconds register is the stop flag. It is written on any seconds write whatever the hold state, and it reads back. While it is set, no tick advances the time.
- R12: Bit 7 of the hours register (kick flag) and bit 6 of the day-of-week register (frequency-test flag) are stored and read back. All other bits outside the field widths read 0. The field widths are seconds 7, minutes 7, hours 6, day 3, date 6, month 5 and year 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Sub-second tick pulse, one cycle wide |
| addr_i | input | 11 | Byte address |
| we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |

## Verification
The bench drives the calendar into every rollover boundary, with the time loaded through the write-hold path:
- a 30-day month;
- a 31-day month;
- February in a leap year and in a non-leap year, including year 00;
- the end of a year.

A wrong month-length table or leap-year test shows up as a skipped or extra date. A commit that does not clear the sub-second divider advances the seconds too early. A freeze bit that stops the live count loses the second that passed during the frozen read. Flag bits that reach the time fields, or time-field writes that leak through while the hold bit is clear, corrupt the time that is read back.

// File: rtl/tod_pkg.sv
package tod_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [4:0] month;
    logic [5:0] date;
    logic [2:0] dow;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } tod_time_t;

  typedef enum logic [2:0] {
    IDX_CTRL  = 3'd0,
    IDX_SEC   = 3'd1,
    IDX_MIN   = 3'd2,
    IDX_HOUR  = 3'd3,
    IDX_DOW   = 3'd4,
    IDX_DATE  = 3'd5,
    IDX_MONTH = 3'd6,
    IDX_YEAR  = 3'd7
  } tod_idx_e;

  localparam tod_time_t TOD_RESET_VAL = '{
    year: 8'h00, month: 5'h01, date: 6'h01, dow: 3'h1,
    hour: 6'h00, min: 7'h00, sec: 7'h00
  };

  // Two-digit packed BCD increment (no range wrap here).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Year (BCD) divisible by four.
  function automatic logic leap_year(input logic [7:0] y);
    return ((({4'b0, y[7:4]} * 8'd10 + {4'b0, y[3:0]}) & 8'h03) == 8'h00);
  endfunction

  // Last valid date (BCD) of a month (BCD).
  function automatic logic [5:0] month_last(input logic [4:0] mo, input logic leap);
    case (mo)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/tod_rst_sync.sv
module tod_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/tod_subsec.sv
module tod_subsec #(
  parameter int unsigned SUBSEC_DIV = 4
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hold_i,
  input  logic clear_i,
  output logic pulse_o
);
  generate
    if (SUBSEC_DIV <= 1) begin : g_direct
      assign pulse_o = tick_i && !hold_i && !clear_i;
    end else begin : g_count
      localparam int unsigned CNT_W = $clog2(SUBSEC_DIV);
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SUBSEC_DIV - 1);

      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             cnt_en;

      assign cnt_en  = clear_i || (tick_i && !hold_i);
      assign pulse_o = tick_i && !hold_i && !clear_i && (cnt_q == CNT_LAST);

      always_comb begin
        cnt_d = cnt_q;
        if (clear_i)                cnt_d = '0;
        else if (cnt_q == CNT_LAST) cnt_d = '0;
        else                        cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      // R11: a stopped clock keeps its sub-second phase
      a_r11_phase_frozen: assert property (@(posedge clk) disable iff (!rst_ni)
        (hold_i && !clear_i) |=> $stable(cnt_q));
      // R8: commit restarts the second
      a_r8_phase_cleared: assert property (@(posedge clk) disable iff (!rst_ni)
        clear_i |=> (cnt_q == '0));
    end
  endgenerate
endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
  import tod_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      adv_i,
  input  logic      load_i,
  input  tod_time_t load_val_i,
  output tod_time_t now_o
);
  tod_time_t cur_q, nxt;
  logic      cur_en;
  logic      c_min, c_hour, c_day, c_mon, c_year;
  logic [5:0] last_date;

  assign cur_en    = load_i || adv_i;
  assign last_date = month_last(cur_q.month, leap_year(cur_q.year));

  always_comb begin
    nxt    = cur_q;
    c_min  = 1'b0;
    c_hour = 1'b0;
    c_day  = 1'b0;
    c_mon  = 1'b0;
    c_year = 1'b0;
    if (load_i) begin
      nxt = load_val_i;
    end else if (adv_i) begin
      if (cur_q.sec >= 7'h59) begin
        nxt.sec = '0;
        c_min   = 1'b1;
      end else begin
        nxt.sec = 7'(bcd_inc({1'b0, cur_q.sec}));
      end
      if (c_min) begin
        if (cur_q.min >= 7'h59) begin
          nxt.min = '0;
          c_hour  = 1'b1;
        end else begin
          nxt.min = 7'(bcd_inc({1'b0, cur_q.min}));
        end
      end
      if (c_hour) begin
        if (cur_q.hour >= 6'h23) begin
          nxt.hour = '0;
          c_day    = 1'b1;
        end else begin
          nxt.hour = 6'(bcd_inc({2'b0, cur_q.hour}));
        end
      end
      if (c_day) begin
        nxt.dow = (cur_q.dow >= 3'd7 || cur_q.dow == 3'd0) ? 3'd1 : cur_q.dow + 3'd1;
        if (cur_q.date >= last_date) begin
          nxt.date = 6'h01;
          c_mon    = 1'b1;
        end else begin
          nxt.date = 6'(bcd_inc({2'b0, cur_q.date}));
        end
      end
      if (c_mon) begin
        if (cur_q.month >= 5'h12) begin
          nxt.month = 5'h01;
          c_year    = 1'b1;
        end else begin
          nxt.month = 5'(bcd_inc({3'b0, cur_q.month}));
        end
      end
      if (c_year) begin
        nxt.year = (cur_q.year >= 8'h99) ? 8'h00 : bcd_inc(cur_q.year);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cur_q <= TOD_RESET_VAL;
    else if (cur_en) cur_q <= nxt;
  end

  assign now_o = cur_q;

  // R3: no second pulse, no change
  a_r3_hold_without_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(cur_q));
  // R4: seconds wrap and carry
  a_r4_sec_wrap: assert property (@(posedge clk) disable iff (!rst_ni)
    (adv_i && !load_i && cur_q.sec == 7'h59 && cur_q.min == 7'h10)
      |=> (cur_q.sec == 7'h00 && cur_q.min == 7'h11));
  // R5: leap February reaches the 29th
  a_r5_leap_feb29: assert property (@(posedge clk) disable iff (!rst_ni)
    (adv_i && !load_i && cur_q.sec == 7'h59 && cur_q.min == 7'h59 &&
     cur_q.hour == 6'h23 && cur_q.month == 5'h02 && cur_q.date == 6'h28 &&
     leap_year(cur_q.year)) |=> (cur_q.date == 6'h29 && cur_q.month == 5'h02));
  // R6: end of century
  a_r6_year_wrap: assert property (@(posedge clk) disable iff (!rst_ni)
    (adv_i && !load_i && cur_q.sec == 7'h59 && cur_q.min == 7'h59 &&
     cur_q.hour == 6'h23 && cur_q.month == 5'h12 && cur_q.date == 6'h31 &&
     cur_q.year == 8'h99) |=> (cur_q.year == 8'h00 && cur_q.month == 5'h01 &&
     cur_q.date == 6'h01));
  // R8: load takes the presented value
  a_r8_load_value: assert property (@(posedge clk) disable iff (!rst_ni)
    load_i |=> (cur_q == $past(load_val_i)));
endmodule

// File: rtl/tod_bcd_clock.sv
module tod_bcd_clock
  import tod_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 11,
  parameter logic [ADDR_W-1:0]  BLOCK_BASE = 11'h7F8,
  parameter int unsigned        SUBSEC_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int unsigned IDX_W = 3;
  localparam logic [ADDR_W-IDX_W-1:0] BASE_HI = BLOCK_BASE[ADDR_W-1:IDX_W];

  logic      rst_ni;
  logic      hit, wr, commit, sec_pulse;
  tod_idx_e  idx;
  tod_time_t live, hold_q, hold_d, snap_q, src;

  logic       wr_hold_q, wr_hold_d;
  logic       rd_frz_q, rd_frz_d;
  logic       sign_q, sign_d;
  logic [4:0] cal_q, cal_d;
  logic       stop_q, stop_d, kick_q, kick_d, ftest_q, ftest_d;
  logic [7:0] rd_val;

  tod_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_no (rst_ni)
  );

  assign hit    = (addr_i[ADDR_W-1:IDX_W] == BASE_HI);
  assign idx    = tod_idx_e'(addr_i[IDX_W-1:0]);
  assign wr     = we_i && hit;
  assign commit = wr && (idx == IDX_CTRL) && !wdata_i[7] && wr_hold_q;

  tod_subsec #(.SUBSEC_DIV(SUBSEC_DIV)) u_subsec (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .hold_i  (stop_q),
    .clear_i (commit),
    .pulse_o (sec_pulse)
  );

  tod_calendar u_calendar (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .adv_i      (sec_pulse),
    .load_i     (commit),
    .load_val_i (hold_q),
    .now_o      (live)
  );

  // Control register and flag bits.
  always_comb begin
    wr_hold_d = wr_hold_q;
    rd_frz_d  = rd_frz_q;
    sign_d    = sign_q;
    cal_d     = cal_q;
    stop_d    = stop_q;
    kick_d    = kick_q;
    ftest_d   = ftest_q;
    if (wr) begin
      case (idx)
        IDX_CTRL: begin
          wr_hold_d = wdata_i[7];
          rd_frz_d  = wdata_i[6];
          sign_d    = wdata_i[5];
          cal_d     = wdata_i[4:0];
        end
        IDX_SEC:  stop_d  = wdata_i[7];
        IDX_HOUR: kick_d  = wdata_i[7];
        IDX_DOW:  ftest_d = wdata_i[6];
        default: ;
      endcase
    end
  end

  // Holding copy: tracks live while hold is clear, takes writes while set.
  always_comb begin
    hold_d = hold_q;
    if (!wr_hold_q) begin
      hold_d = live;
    end else if (wr) begin
      case (idx)
        IDX_SEC:   hold_d.sec   = wdata_i[6:0];
        IDX_MIN:   hold_d.min   = wdata_i[6:0];
        IDX_HOUR:  hold_d.hour  = wdata_i[5:0];
        IDX_DOW:   hold_d.dow   = wdata_i[2:0];
        IDX_DATE:  hold_d.date  = wdata_i[5:0];
        IDX_MONTH: hold_d.month = wdata_i[4:0];
        IDX_YEAR:  hold_d.year  = wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_hold_q <= 1'b0;
      rd_frz_q  <= 1'b0;
      sign_q    <= 1'b0;
      cal_q     <= '0;
      stop_q    <= 1'b0;
      kick_q    <= 1'b0;
      ftest_q   <= 1'b0;
      hold_q    <= TOD_RESET_VAL;
    end else begin
      wr_hold_q <= wr_hold_d;
      rd_frz_q  <= rd_frz_d;
      sign_q    <= sign_d;
      cal_q     <= cal_d;
      stop_q    <= stop_d;
      kick_q    <= kick_d;
      ftest_q   <= ftest_d;
      hold_q    <= hold_d;
    end
  end

  // Readable copy: follows live one cycle behind unless frozen.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)        snap_q <= TOD_RESET_VAL;
    else if (!rd_frz_q) snap_q <= live;
  end

  assign src = wr_hold_q ? hold_q : snap_q;

  always_comb begin
    case (idx)
      IDX_CTRL:  rd_val = {wr_hold_q, rd_frz_q, sign_q, cal_q};
      IDX_SEC:   rd_val = {stop_q, src.sec};
      IDX_MIN:   rd_val = {1'b0, src.min};
      IDX_HOUR:  rd_val = {kick_q, 1'b0, src.hour};
      IDX_DOW:   rd_val = {1'b0, ftest_q, 3'b000, src.dow};
      IDX_DATE:  rd_val = {2'b00, src.date};
      IDX_MONTH: rd_val = {3'b000, src.month};
      IDX_YEAR:  rd_val = src.year;
      default:   rd_val = 8'h00;
    endcase
  end

  assign rdata_o = hit ? rd_val : 8'h00;

  // R8: the commit lands the holding copy in the live count
  a_r8_commit_loads: assert property (@(posedge clk) disable iff (!rst_ni)
    commit |=> (live == $past(hold_q)));
  // R9: a frozen copy does not move
  a_r9_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_frz_q |=> $stable(snap_q));
  // R7: holding copy follows live while hold is clear
  a_r7_hold_tracks_live: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_hold_q |=> (hold_q == $past(live)));
  // R2: writes outside the window change no control state
  a_r2_miss_no_effect: assert property (@(posedge clk) disable iff (!rst_ni)
    (we_i && !hit) |=> $stable({wr_hold_q, rd_frz_q, sign_q, cal_q, stop_q, kick_q, ftest_q, hold_q}));
endmodule

// File: tb/tod_bcd_clock_tb.sv
module tod_bcd_clock_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  localparam logic [10:0] A_CTRL  = 11'h7F8;
  localparam logic [10:0] A_SEC   = 11'h7F9;
  localparam logic [10:0] A_MIN   = 11'h7FA;
  localparam logic [10:0] A_HOUR  = 11'h7FB;
  localparam logic [10:0] A_DOW   = 11'h7FC;
  localparam logic [10:0] A_DATE  = 11'h7FD;
  localparam logic [10:0] A_MONTH = 11'h7FE;
  localparam logic [10:0] A_YEAR  = 11'h7FF;

  logic        clk, rst_n, tick, we;
  logic [10:0] addr;
  logic [7:0]  wdata, rdata;
  int          n_tests, n_fail;

  tod_bcd_clock #(.ADDR_W(11), .BLOCK_BASE(11'h7F8), .SUBSEC_DIV(DIV)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .addr_i  (addr),
    .we_i    (we),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic expect_reg(input string req, input logic [10:0] a, input logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    check(req, v, e);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                          input logic [7:0] y);
    wr(A_CTRL, 8'h80);
    wr(A_SEC, s); wr(A_MIN, m); wr(A_HOUR, h); wr(A_DOW, dw);
    wr(A_DATE, dt); wr(A_MONTH, mo); wr(A_YEAR, y);
    wr(A_CTRL, 8'h00);
  endtask

  task automatic t_reset;
    expect_reg("R1 ctrl", A_CTRL, 8'h00);
    expect_reg("R1 sec", A_SEC, 8'h00);
    expect_reg("R1 min", A_MIN, 8'h00);
    expect_reg("R1 hour", A_HOUR, 8'h00);
    expect_reg("R1 dow", A_DOW, 8'h01);
    expect_reg("R1 date", A_DATE, 8'h01);
    expect_reg("R1 month", A_MONTH, 8'h01);
    expect_reg("R1 year", A_YEAR, 8'h00);
  endtask

  task automatic t_tick_count;
    pulse(DIV - 1);
    expect_reg("R3 short of a second", A_SEC, 8'h00);
    pulse(1);
    expect_reg("R3 one second", A_SEC, 8'h01);
    set_time(8'h09, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    pulse(DIV);
    expect_reg("R3 units to tens", A_SEC, 8'h10);
  endtask

  task automatic t_carry_chain;
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h15, 8'h03, 8'h42);
    pulse(DIV);
    expect_reg("R4 sec wrap", A_SEC, 8'h00);
    expect_reg("R4 min wrap", A_MIN, 8'h00);
    expect_reg("R4 hour wrap", A_HOUR, 8'h00);
    expect_reg("R4 dow wrap", A_DOW, 8'h01);
    expect_reg("R4 date step", A_DATE, 8'h16);
    expect_reg("R4 month kept", A_MONTH, 8'h03);
  endtask

  task automatic t_month_len;
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h21);
    pulse(DIV);
    expect_reg("R5 30-day date", A_DATE, 8'h01);
    expect_reg("R5 30-day month", A_MONTH, 8'h05);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h01, 8'h21);
    pulse(DIV);
    expect_reg("R5 31-day month day 31", A_DATE, 8'h31);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h01, 8'h21);
    pulse(DIV);
    expect_reg("R5 31-day wrap", A_DATE, 8'h01);
    expect_reg("R5 31-day month", A_MONTH, 8'h02);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
    pulse(DIV);
    expect_reg("R5 feb non-leap date", A_DATE, 8'h01);
    expect_reg("R5 feb non-leap month", A_MONTH, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    pulse(DIV);
    expect_reg("R5 feb leap 29th", A_DATE, 8'h29);
    expect_reg("R5 feb leap month", A_MONTH, 8'h02);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h24);
    pulse(DIV);
    expect_reg("R5 feb leap wrap", A_DATE, 8'h01);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00);
    pulse(DIV);
    expect_reg("R5 year 00 leap", A_DATE, 8'h29);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h18);
    pulse(DIV);
    expect_reg("R5 year 18 not leap", A_DATE, 8'h01);
  endtask

  task automatic t_year_wrap;
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
    pulse(DIV);
    expect_reg("R6 month wrap", A_MONTH, 8'h01);
    expect_reg("R6 year wrap", A_YEAR, 8'h00);
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h19);
    pulse(DIV);
    expect_reg("R6 year step", A_YEAR, 8'h20);
  endtask

  task automatic t_hold;
    set_time(8'h21, 8'h05, 8'h10, 8'h03, 8'h12, 8'h06, 8'h30);
    wr(A_SEC, 8'h45);
    expect_reg("R7 write ignored while hold clear", A_SEC, 8'h21);
    wr(A_CTRL, 8'h80);
    wr(A_MIN, 8'hFF);
    expect_reg("R7 holding masked", A_MIN, 8'h7F);
    wr(A_MIN, 8'h42);
    expect_reg("R7 holding readback", A_MIN, 8'h42);
    expect_reg("R7 ctrl shows hold", A_CTRL, 8'h80);
    wr(A_CTRL, 8'h00);
    expect_reg("R7 committed min", A_MIN, 8'h42);
  endtask

  task automatic t_commit_phase;
    set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    pulse(2);
    wr(A_CTRL, 8'h80);
    wr(A_SEC, 8'h20);
    wr(A_CTRL, 8'h00);
    pulse(DIV - 1);
    expect_reg("R8 phase cleared", A_SEC, 8'h20);
    pulse(1);
    expect_reg("R8 full second after commit", A_SEC, 8'h21);
  endtask

  task automatic t_freeze;
    set_time(8'h58, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(A_CTRL, 8'h40);
    pulse(DIV);
    expect_reg("R9 frozen copy", A_SEC, 8'h58);
    wr(A_CTRL, 8'h00);
    expect_reg("R9 live after release", A_SEC, 8'h59);
  endtask

  task automatic t_calib;
    set_time(8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(A_CTRL, 8'h3F);
    expect_reg("R10 sign and cal readback", A_CTRL, 8'h3F);
    pulse(DIV);
    expect_reg("R10 counting unaffected", A_SEC, 8'h31);
    wr(A_CTRL, 8'h00);
    expect_reg("R10 cleared", A_CTRL, 8'h00);
  endtask

  task automatic t_stop;
    set_time(8'h40, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(A_SEC, 8'h80);
    expect_reg("R11 stop readback", A_SEC, 8'hC0);
    pulse(2 * DIV);
    expect_reg("R11 stopped", A_SEC, 8'hC0);
    wr(A_SEC, 8'h00);
    expect_reg("R11 restart", A_SEC, 8'h40);
    pulse(DIV);
    expect_reg("R11 runs again", A_SEC, 8'h41);
  endtask

  task automatic t_flags;
    set_time(8'h00, 8'h00, 8'h12, 8'h05, 8'h01, 8'h01, 8'h00);
    wr(A_CTRL, 8'h80);
    wr(A_HOUR, 8'hFF);
    expect_reg("R12 kick and hour mask", A_HOUR, 8'hBF);
    wr(A_DOW, 8'hFF);
    expect_reg("R12 ftest and dow mask", A_DOW, 8'h47);
    wr(A_HOUR, 8'h92);
    wr(A_DOW, 8'h45);
    wr(A_CTRL, 8'h00);
    expect_reg("R12 kick kept, hour clean", A_HOUR, 8'h92);
    expect_reg("R12 ftest kept, dow clean", A_DOW, 8'h45);
    wr(A_HOUR, 8'h00);
    wr(A_DOW, 8'h00);
    expect_reg("R12 kick cleared", A_HOUR, 8'h12);
    expect_reg("R12 ftest cleared", A_DOW, 8'h05);
  endtask

  task automatic t_addr_map;
    expect_reg("R2 low address reads zero", 11'h000, 8'h00);
    expect_reg("R2 below window reads zero", 11'h7F0, 8'h00);
    wr(11'h3F8, 8'hBF);
    expect_reg("R2 alias write ignored ctrl", A_CTRL, 8'h00);
    wr(11'h3F9, 8'h80);
    expect_reg("R2 alias write ignored sec", A_SEC, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; tick = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_tick_count();
    t_carry_chain();
    t_month_len();
    t_year_wrap();
    t_hold();
    t_commit_phase();
    t_freeze();
    t_calib();
    t_stop();
    t_flags();
    set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    t_addr_map();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule